// File: doc/BRIEF.md
# Late-write pipelined burst SRAM

This block is a synthesizable model of a synchronous single-port memory whose bus never needs idle turnaround cycles. A command (read, write or deselect) is taken on a clock edge while the advance/load strobe is low. A read returns its word on the output bus two edges later. A write takes its address and byte enables with the command, and takes its data from the bus input two edges later. Because reads and writes use the same two-slot delay, any sequence of reads and writes keeps the bus busy on every cycle.

With the advance strobe high, the block ignores the external address, chip enables and read/write select. It repeats the last loaded operation on the next address of a four-beat burst. The burst order is interleaved or linear, chosen by a static input. A clock-enable hold input freezes the whole machine. Writes are masked per 9-bit lane. A read that follows closely behind a write to the same word returns the new data, because writes retire through a one-entry buffer that reads bypass lane by lane. The bus split into in and out ports plus a drive enable is gated by an asynchronous output enable.

Top module: `zt_sram`

## Requirements
- R1: A read loaded at edge k (adv low, ce0_n low, ce1 high, ce2_n low, rd_wr high) presents the stored word on dq_out with rd_valid set after edge k+2.
- R2: A write loaded at edge k (rd_wr low) stores the dq_in value sampled at edge k+2 at the address given at edge k. A later read returns that value.
- R3: Reads and writes can be loaded on consecutive edges in any order. A read loaded one edge after a write to the same address returns the newly written lanes.
- R4: While adv is high, addr, the chip enables and rd_wr have no effect. Each such edge repeats the last loaded operation at the next beat address. Only the two low address bits change, and they wrap after four beats.
- R5: With order_il high, the low two bits of beat n are the start bits XOR n.
- R6: With order_il low, the low two bits of beat n are (start bits + n) mod 4.
- R7: An edge with hold high changes no state. dq_out and dq_oe stay the same, no write lands and the burst does not step.
- R8: A load with ce0_n high, ce1 low or ce2_n high is a deselect. Two edges later rd_valid is low, and operations loaded before it still complete.
- R9: bw_n is active low. bw_n[0] gates bits 8:0 and bw_n[1] gates bits 17:9. A lane whose bit is high keeps its old contents. The enables are taken on every load and every burst beat.
- R10: dq_oe is high exactly when oe_n is low and a read result is being presented. It follows oe_n with no clock.
- R11: After reset rd_valid and dq_oe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the control state |
| hold | input | 1 | High freezes all state for that edge |
| ce0_n | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| adv | input | 1 | High: burst beat; low: load a new command |
| rd_wr | input | 1 | High read, low write, on a load |
| bw_n | input | LANES (2) | Active-low lane write enables |
| addr | input | ADDR_W (6) | Word address |
| order_il | input | 1 | High interleaved burst order, low linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | LANES*LANE_W (18) | Write data from the shared bus |
| dq_out | output | LANES*LANE_W (18) | Read data to the shared bus |
| dq_oe | output | 1 | Bus drive enable |
| rd_valid | output | 1 | A read result is being presented |

## Verification
The first pass fills every word with full-width writes. Later reads then separate correct addressing from aliasing. Random reads, write/read alternation to the same word and back-to-back bursts show whether the two-slot latency and the write-buffer bypass line up. Bursts from several starting offsets in both orders, driven with junk on the ignored inputs, show whether the beat sequence and the wrap are right. Partial lane writes, hold cycles placed between a write command and its data, deselects from each chip enable and oe_n toggles each test one of the gating paths on its own.

// File: rtl/zt_pkg.sv
package zt_pkg;
   typedef enum logic [1:0] {
      OP_DS = 2'd0,
      OP_RD = 2'd1,
      OP_WR = 2'd2
   } op_e;
endpackage

// File: rtl/zt_cmd_seq.sv
module zt_cmd_seq #(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              ce0_n,
   input  logic              ce1,
   input  logic              ce2_n,
   input  logic              adv,
   input  logic              rd_wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic              order_il,
   output zt_pkg::op_e       op,
   output logic [ADDR_W-1:0] a
);
   import zt_pkg::*;

   op_e               op_q;
   logic [ADDR_W-1:0] base_q;
   logic [1:0]        cnt_q, cnt_nx, lo;
   logic              sel;

   assign sel = !ce0_n && ce1 && !ce2_n;

   always_comb begin
      if (!adv) begin
         cnt_nx = 2'd0;
         lo     = addr[1:0];
         a      = addr;
         op     = sel ? (rd_wr ? OP_RD : OP_WR) : OP_DS;
      end else begin
         cnt_nx = cnt_q + 2'd1;
         lo     = order_il ? (base_q[1:0] ^ cnt_nx) : (base_q[1:0] + cnt_nx);
         a      = {base_q[ADDR_W-1:2], lo};
         op     = op_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= OP_DS;
         base_q <= '0;
         cnt_q  <= '0;
      end else if (!hold) begin
         cnt_q <= cnt_nx;
         if (!adv) begin
            op_q   <= op;
            base_q <= addr;
         end
      end
   end

   // R4
   burst_keeps_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && adv) |=> (op_q == $past(op_q)));
endmodule

// File: rtl/zt_pipe.sv
module zt_pipe #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] st;

   for (genvar i = 0; i < STAGES; i++) begin : g_st
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     st[i] <= '0;
         else if (!hold) st[i] <= (i == 0) ? d : st[(i == 0) ? 0 : i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/zt_store.sv
module zt_store #(
   parameter int ADDR_W = 6,
   parameter int LANE_W = 9,
   parameter int LANES  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    hold,
   input  zt_pkg::op_e             op,
   input  logic [ADDR_W-1:0]       a,
   input  logic [LANES-1:0]        bw_n,
   input  logic [LANES*LANE_W-1:0] din,
   output logic [LANES*LANE_W-1:0] dout,
   output logic                    rd_valid
);
   import zt_pkg::*;
   localparam int WORDS  = 2**ADDR_W;
   localparam int DATA_W = LANES*LANE_W;

   logic              wb_vld;
   logic [ADDR_W-1:0] wb_a;
   logic [LANES-1:0]  wb_bw_n;
   logic [DATA_W-1:0] wb_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_vld   <= 1'b0;
         rd_valid <= 1'b0;
         wb_a     <= '0;
         wb_bw_n  <= '1;
         wb_d     <= '0;
      end else if (!hold) begin
         wb_vld   <= (op == OP_WR);
         rd_valid <= (op == OP_RD);
         if (op == OP_WR) begin
            wb_a    <= a;
            wb_bw_n <= bw_n;
            wb_d    <= din;
         end
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] mem [WORDS];
      logic [LANE_W-1:0] rdl;
      logic              fwd;

      assign fwd = wb_vld && !wb_bw_n[l] && (wb_a == a);
      assign rdl = fwd ? wb_d[l*LANE_W +: LANE_W] : mem[a];

      always_ff @(posedge clk) begin
         if (rst_n && !hold && wb_vld && !wb_bw_n[l])
            mem[wb_a] <= wb_d[l*LANE_W +: LANE_W];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      dout[l*LANE_W +: LANE_W] <= '0;
         else if (!hold && op == OP_RD)   dout[l*LANE_W +: LANE_W] <= rdl;
      end
   end
endmodule

// File: rtl/zt_sram.sv
module zt_sram #(
   parameter int ADDR_W = 6,
   parameter int LANE_W = 9,
   parameter int LANES  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    hold,
   input  logic                    ce0_n,
   input  logic                    ce1,
   input  logic                    ce2_n,
   input  logic                    adv,
   input  logic                    rd_wr,
   input  logic [LANES-1:0]        bw_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    order_il,
   input  logic                    oe_n,
   input  logic [LANES*LANE_W-1:0] dq_in,
   output logic [LANES*LANE_W-1:0] dq_out,
   output logic                    dq_oe,
   output logic                    rd_valid
);
   import zt_pkg::*;
   localparam int LAT   = 2;
   localparam int PIPEW = 2 + ADDR_W + LANES;

   if (ADDR_W < 3) begin : g_bad_addr
      $error("zt_sram: ADDR_W must be at least 3");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("zt_sram: LANES and LANE_W must be positive");
   end

   op_e               op_c, s2_op;
   logic [ADDR_W-1:0] a_c, s2_a;
   logic [LANES-1:0]  s2_bw;
   logic [PIPEW-1:0]  s2_vec;

   zt_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .hold(hold),
      .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n),
      .adv(adv), .rd_wr(rd_wr), .addr(addr), .order_il(order_il),
      .op(op_c), .a(a_c)
   );

   zt_pipe #(.W(PIPEW), .STAGES(LAT)) u_pipe (
      .clk(clk), .rst_n(rst_n), .hold(hold),
      .d({op_c, a_c, bw_n}), .q(s2_vec)
   );

   assign s2_op = op_e'(s2_vec[PIPEW-1 -: 2]);
   assign s2_a  = s2_vec[LANES +: ADDR_W];
   assign s2_bw = s2_vec[LANES-1:0];

   zt_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_store (
      .clk(clk), .rst_n(rst_n), .hold(hold),
      .op(s2_op), .a(s2_a), .bw_n(s2_bw), .din(dq_in),
      .dout(dq_out), .rd_valid(rd_valid)
   );

   assign dq_oe = rd_valid && !oe_n;

   // R1
   read_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && s2_op == OP_RD) |=> rd_valid);
   // R8
   deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && s2_op == OP_DS) |=> !rd_valid);
   // R7
   hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> ($stable(dq_out) && $stable(rd_valid)));
   // R10
   drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> !oe_n);
endmodule

// File: tb/sim_zt_sram.sv
module sim_zt_sram;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 6;
   localparam int NW = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hold = 1'b0, ce0_n = 1'b1, ce1 = 1'b0, ce2_n = 1'b1;
   logic        adv = 1'b0, rd_wr = 1'b1, order_il = 1'b1, oe_n = 1'b0;
   logic [1:0]  bw_n = 2'b11;
   logic [AW-1:0] addr = '0;
   logic [17:0] dq_in = '0;
   logic [17:0] dq_out;
   logic        dq_oe, rd_valid;

   int checks = 0, errors = 0;
   string tag = "R11";

   // reference state
   logic [17:0] mm [NW];
   int p1op = 0, p1a = 0, p2op = 0, p2a = 0;
   logic [1:0] p1bw = 2'b11, p2bw = 2'b11;
   int m_op = 0, m_base = 0, m_cnt = 0;
   logic exp_valid = 1'b0;
   logic [17:0] exp_data = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   zt_sram u0 (
      .clk(clk), .rst_n(rst_n), .hold(hold), .ce0_n(ce0_n), .ce1(ce1),
      .ce2_n(ce2_n), .adv(adv), .rd_wr(rd_wr), .bw_n(bw_n), .addr(addr),
      .order_il(order_il), .oe_n(oe_n), .dq_in(dq_in),
      .dq_out(dq_out), .dq_oe(dq_oe), .rd_valid(rd_valid)
   );

   task automatic compare();
      logic eoe;
      eoe = exp_valid && !oe_n;
      checks++;
      if (dq_oe !== eoe || rd_valid !== exp_valid) begin
         errors++;
         $display("FAIL %s dq_oe=%b rd_valid=%b expected %b %b", tag, dq_oe, rd_valid, eoe, exp_valid);
      end
      if (exp_valid) begin
         checks++;
         if (dq_out !== exp_data) begin
            errors++;
            $display("FAIL %s dq_out=%h expected %h", tag, dq_out, exp_data);
         end
      end
   endtask

   task automatic step(input logic h, input logic ad, input logic [2:0] ce,
                       input logic rd, input logic [1:0] bw, input int a);
      int lo, ea;
      hold = h; adv = ad; {ce0_n, ce1, ce2_n} = ce; rd_wr = rd; bw_n = bw;
      addr = AW'(a);
      dq_in = 18'($urandom);
      @(posedge clk);
      if (!h) begin
         if (p2op == 2) begin
            if (!p2bw[0]) mm[p2a][8:0]  = dq_in[8:0];
            if (!p2bw[1]) mm[p2a][17:9] = dq_in[17:9];
         end
         exp_valid = (p2op == 1);
         if (p2op == 1) exp_data = mm[p2a];
         p2op = p1op; p2a = p1a; p2bw = p1bw;
         if (!ad) begin
            m_op = (ce == 3'b010) ? (rd ? 1 : 2) : 0;
            m_base = a; m_cnt = 0; ea = a;
         end else begin
            m_cnt = (m_cnt + 1) % 4;
            lo = order_il ? ((m_base % 4) ^ m_cnt) : (((m_base % 4) + m_cnt) % 4);
            ea = (m_base & ~3) | lo;
         end
         p1op = m_op; p1a = ea; p1bw = bw;
      end
      @(negedge clk);
      compare();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 3'b110, 1, 2'b11, 0);
   endtask

   task automatic burst(input logic rd, input int a, input logic [1:0] bw);
      step(0, 0, 3'b010, rd, bw, a);
      // ignored inputs driven with junk during beats
      for (int i = 0; i < 3; i++) step(0, 1, 3'($urandom), 1'($urandom), bw, int'($urandom % NW));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk); @(negedge clk);
      tag = "R11"; compare();
      rst_n = 1'b1;
      idle(2);

      tag = "R2";
      order_il = 1'b1;
      for (int b = 0; b < NW; b += 4) burst(0, b + (b/4) % 4, 2'b00);
      idle(2);

      tag = "R1";
      for (int i = 0; i < 24; i++) step(0, 0, 3'b010, 1, 2'b11, int'($urandom % NW));
      idle(2);

      tag = "R3";
      for (int i = 0; i < 20; i++) begin
         int a = int'($urandom % NW);
         step(0, 0, 3'b010, 0, 2'b00, a);
         step(0, 0, 3'b010, 1, 2'b11, a);
      end
      for (int i = 0; i < 30; i++)
         step(0, 0, 3'b010, 1'($urandom), 2'b00, int'($urandom % 8));
      idle(2);

      tag = "R5";
      order_il = 1'b1;
      for (int s = 0; s < 4; s++) burst(1, 8 + s, 2'b11);
      burst(0, 18, 2'b00);
      burst(1, 17, 2'b11);
      idle(2);

      tag = "R6";
      order_il = 1'b0;
      for (int s = 0; s < 4; s++) burst(1, 20 + s, 2'b11);
      burst(0, 27, 2'b00);
      burst(1, 25, 2'b11);
      idle(2);

      tag = "R4";
      burst(0, 33, 2'b00);
      burst(1, 34, 2'b11);
      step(0, 0, 3'b110, 1, 2'b11, 40);
      for (int i = 0; i < 3; i++) step(0, 1, 3'b010, 1, 2'b11, 41);
      idle(2);

      tag = "R9";
      order_il = 1'b1;
      for (int i = 0; i < 12; i++) begin
         int a = int'($urandom % NW);
         step(0, 0, 3'b010, 0, 2'(i % 3 + 1) ^ 2'b11, a);
         step(0, 0, 3'b010, 1, 2'b11, a);
         step(0, 0, 3'b010, 0, 2'b11, a);
         step(0, 0, 3'b010, 1, 2'b11, a);
      end
      burst(0, 44, 2'b10);
      burst(1, 44, 2'b11);
      idle(2);

      tag = "R7";
      step(0, 0, 3'b010, 0, 2'b00, 50);
      step(1, 0, 3'b010, 1, 2'b00, 51);
      step(1, 1, 3'b010, 0, 2'b00, 52);
      step(0, 0, 3'b010, 1, 2'b11, 50);
      for (int i = 0; i < 40; i++)
         step(1'($urandom % 3 == 0), 1'($urandom % 2), 3'b010, 1'($urandom), 2'($urandom), int'($urandom % NW));
      idle(2);

      tag = "R8";
      for (int i = 0; i < 8; i++) begin
         step(0, 0, 3'b010, 1, 2'b11, i);
         step(0, 0, (i % 3 == 0) ? 3'b110 : (i % 3 == 1) ? 3'b000 : 3'b011, 1, 2'b11, i + 1);
      end
      step(0, 0, 3'b010, 0, 2'b00, 60);
      step(0, 0, 3'b000, 1, 2'b11, 60);
      step(0, 0, 3'b010, 1, 2'b11, 60);
      idle(3);

      tag = "R10";
      for (int i = 0; i < 20; i++) begin
         step(0, 0, 3'b010, 1, 2'b11, int'($urandom % NW));
         oe_n = 1'($urandom);
         #1; compare();
      end
      oe_n = 1'b0;
      idle(3);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule